// File: doc/BRIEF.md
# Page-Buffered Program/Erase Sequencer

This block carries out the write side of a serial flash model. A serial front end decodes the incoming stream and hands it over as three kinds of strobe: an opcode byte, a 24-bit address once all three address bytes have arrived, and then each data byte. A fourth strobe marks the end of the transaction, when chip select returns high. The block keeps a 256-byte page buffer and the last byte received for a single-byte write. When the transaction closes, it starts a self-timed operation on an external byte-wide array port.

Six write operations are supported: single-byte program, page program, page program with auto-erase, page erase, 2 KB block erase and 4 KB block erase. Programming can only clear bits, so every programmed location receives the old value ANDed with the new byte. Erasing fills the addressed unit with FFh. While an operation runs, `busy_o` stays high for a fixed number of cycles set by a parameter for each operation. These counts are scaled stand-ins for the real millisecond timings. An active-low lock input protects the top 64 KB of the array.

Top module: `pe_seq`

## Requirements
- R1: Only opcodes 02h (byte), 11h (page), 82h (page with auto-erase), 81h (page erase), 50h (2 KB erase) and 20h (4 KB erase) start work. Any other opcode followed by an address and an end strobe leaves the array and `busy_o` untouched.
- R2: Byte program writes only the last data byte received, at address bits 18..0. Address bits 23..19 are ignored.
- R3: Page data fills the buffer starting at offset addr[7:0] and wraps from offset 255 to offset 0.
- R4: Page program writes old AND new for each byte. Offsets that received no data are written with FFh, so they keep their old value.
- R5: Auto-erase page program first sets the whole addressed page to FFh and then writes the buffer, all within one busy period of T_AUTO cycles.
- R6: Page erase ignores addr[7:0] and sets the 256 bytes of that page to FFh. Neighbouring pages are left unchanged.
- R7: 2 KB block erase ignores addr[10:0] and sets the 2048 bytes of that block to FFh.
- R8: 4 KB block erase ignores addr[11:0] and sets the 4096 bytes of that block to FFh.
- R9: While `lock_top_ni` is low, a request whose address bits 18..16 are all ones (070000h to 07FFFFh) is refused: nothing is written and `busy_o` stays low. Address 06FFFFh is still writable.
- R10: An operation starts only on `cs_rise_i`. `busy_o` goes high in the cycle after the strobe and stays high for exactly T_BYTE, T_PAGE, T_AUTO, T_PERASE, T_BLK2 or T_BLK4 cycles, depending on the operation.
- R11: Opcode, address, data and end strobes that arrive while `busy_o` is high are discarded. They neither restart the timer nor write the array.
- R12: `arr_we_o` is asserted only while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_valid_i | input | 1 | Opcode byte strobe |
| op_i | input | 8 | Opcode byte |
| addr_valid_i | input | 1 | Address strobe (all three bytes received) |
| addr_i | input | 24 | Address, bits 23..19 ignored |
| data_valid_i | input | 1 | Data byte strobe |
| data_i | input | 8 | Data byte |
| cs_rise_i | input | 1 | End-of-transaction strobe |
| lock_top_ni | input | 1 | Low protects the top 64 KB |
| busy_o | output | 1 | Self-timed operation in progress |
| arr_we_o | output | 1 | Array byte write enable |
| arr_addr_o | output | 19 | Array byte address |
| arr_wdata_o | output | 8 | Array write data |
| arr_rdata_i | input | 8 | Array read data at arr_addr_o, combinational |

## Verification
The assertions check the following on every cycle:
- the busy counter only reloads from idle and then counts down by one per cycle;
- `busy_o` only rises after an accepted end strobe;
- array writes happen only while busy;
- a locked, protected request never raises busy;
- the buffer pointer wraps;
- auto-erase moves into programming only after its erase pass.

Only the bench scenarios can show the resulting memory contents: last-byte-wins, the AND rule, untouched unloaded offsets, erase unit boundaries, and the discarding of commands issued mid-operation. For these, the bench compares the array against its own reference model, and it also checks the exact length of `busy_o` on every clock.

// File: rtl/pe_seq_pkg.sv
package pe_seq_pkg;
  typedef enum logic [2:0] {
    K_NONE, K_BYTE, K_PAGE, K_AUTO, K_PERASE, K_BLK2, K_BLK4
  } kind_e;

  localparam logic [7:0] OP_BYTE   = 8'h02;
  localparam logic [7:0] OP_PAGE   = 8'h11;
  localparam logic [7:0] OP_AUTO   = 8'h82;
  localparam logic [7:0] OP_PERASE = 8'h81;
  localparam logic [7:0] OP_BLK2   = 8'h50;
  localparam logic [7:0] OP_BLK4   = 8'h20;

  function automatic kind_e decode_op(input logic [7:0] op);
    case (op)
      OP_BYTE:   return K_BYTE;
      OP_PAGE:   return K_PAGE;
      OP_AUTO:   return K_AUTO;
      OP_PERASE: return K_PERASE;
      OP_BLK2:   return K_BLK2;
      OP_BLK4:   return K_BLK4;
      default:   return K_NONE;
    endcase
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/pe_page_buf.sv
module pe_page_buf #(
  parameter int PAGE_W = 8,
  parameter int DW     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              set_ptr_i,
  input  logic [PAGE_W-1:0] ptr_i,
  input  logic              wr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [PAGE_W-1:0] rd_idx_i,
  output logic [DW-1:0]     rd_data_o
);
  localparam int DEPTH = 1 << PAGE_W;

  logic [DW-1:0]     mem_q [DEPTH];
  logic [PAGE_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
      ptr_q <= '0;
    end else begin
      if (clr_i) begin
        for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
      end else if (wr_i) begin
        mem_q[ptr_q] <= wdata_i;
      end
      if (set_ptr_i) ptr_q <= ptr_i;
      else if (wr_i) ptr_q <= ptr_q + 1'b1;
    end
  end

  assign rd_data_o = mem_q[rd_idx_i];

  // R3
  ptr_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !set_ptr_i && ptr_q == {PAGE_W{1'b1}}) |=> ptr_q == '0);
endmodule

// File: rtl/pe_busy_timer.sv
module pe_busy_timer #(
  parameter int CW = 13
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [CW-1:0] len_i,
  output logic          busy_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (start_i)        cnt_q <= len_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  // R11
  reload_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> cnt_q == '0);
  // R10
  countdown_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
  // R10
  busy_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
endmodule

// File: rtl/pe_walker.sv
module pe_walker
  import pe_seq_pkg::*;
#(
  parameter int AW     = 19,
  parameter int PAGE_W = 8,
  parameter int BLK2_W = 11,
  parameter int BLK4_W = 12,
  parameter int DW     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  kind_e             kind_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     byte_i,
  output logic [PAGE_W-1:0] buf_idx_o,
  input  logic [DW-1:0]     buf_data_i,
  input  logic [DW-1:0]     arr_rdata_i,
  output logic              arr_we_o,
  output logic [AW-1:0]     arr_addr_o,
  output logic [DW-1:0]     arr_wdata_o
);
  localparam int IW = BLK4_W;

  typedef enum logic [1:0] {W_IDLE, W_ERASE, W_PROG, W_BYTE} wst_e;

  wst_e          st_q;
  logic [IW-1:0] idx_q, last_q;
  logic [AW-1:0] base_q;
  logic          then_prog_q;

  function automatic logic [AW-1:0] align(input logic [AW-1:0] a, input int w);
    return a & ({AW{1'b1}} << w);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= W_IDLE;
      idx_q       <= '0;
      last_q      <= '0;
      base_q      <= '0;
      then_prog_q <= 1'b0;
    end else if (start_i) begin
      idx_q       <= '0;
      then_prog_q <= 1'b0;
      base_q      <= align(addr_i, PAGE_W);
      last_q      <= IW'((1 << PAGE_W) - 1);
      case (kind_i)
        K_BYTE:   begin st_q <= W_BYTE; base_q <= addr_i; end
        K_PAGE:   st_q <= W_PROG;
        K_AUTO:   begin st_q <= W_ERASE; then_prog_q <= 1'b1; end
        K_PERASE: st_q <= W_ERASE;
        K_BLK2: begin
          st_q   <= W_ERASE;
          base_q <= align(addr_i, BLK2_W);
          last_q <= IW'((1 << BLK2_W) - 1);
        end
        K_BLK4: begin
          st_q   <= W_ERASE;
          base_q <= align(addr_i, BLK4_W);
          last_q <= IW'((1 << BLK4_W) - 1);
        end
        default:  st_q <= W_IDLE;
      endcase
    end else begin
      case (st_q)
        W_ERASE: begin
          if (idx_q == last_q) begin
            idx_q       <= '0;
            then_prog_q <= 1'b0;
            st_q        <= then_prog_q ? W_PROG : W_IDLE;
            last_q      <= IW'((1 << PAGE_W) - 1);
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        W_PROG: begin
          if (idx_q == last_q) st_q <= W_IDLE;
          else                 idx_q <= idx_q + 1'b1;
        end
        W_BYTE:  st_q <= W_IDLE;
        default: st_q <= W_IDLE;
      endcase
    end
  end

  assign buf_idx_o = idx_q[PAGE_W-1:0];

  always_comb begin
    arr_we_o    = 1'b0;
    arr_addr_o  = base_q | AW'(idx_q);
    arr_wdata_o = '1;
    case (st_q)
      W_ERASE: arr_we_o = 1'b1;
      W_PROG: begin
        arr_we_o    = 1'b1;
        arr_wdata_o = arr_rdata_i & buf_data_i;
      end
      W_BYTE: begin
        arr_we_o    = 1'b1;
        arr_addr_o  = base_q;
        arr_wdata_o = arr_rdata_i & byte_i;
      end
      default: arr_we_o = 1'b0;
    endcase
  end

  // R5
  erase_then_prog_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == W_PROG && $past(st_q) == W_ERASE) |-> $past(then_prog_q));
endmodule

// File: rtl/pe_seq.sv
module pe_seq
  import pe_seq_pkg::*;
#(
  parameter int AW       = 19,
  parameter int PAGE_W   = 8,
  parameter int PROT_W   = 3,
  parameter int T_BYTE   = 8,
  parameter int T_PAGE   = 300,
  parameter int T_AUTO   = 560,
  parameter int T_PERASE = 280,
  parameter int T_BLK2   = 2100,
  parameter int T_BLK4   = 4200
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          op_valid_i,
  input  logic [7:0]    op_i,
  input  logic          addr_valid_i,
  input  logic [23:0]   addr_i,
  input  logic          data_valid_i,
  input  logic [7:0]    data_i,
  input  logic          cs_rise_i,
  input  logic          lock_top_ni,
  output logic          busy_o,
  output logic          arr_we_o,
  output logic [AW-1:0] arr_addr_o,
  output logic [7:0]    arr_wdata_o,
  input  logic [7:0]    arr_rdata_i
);
  localparam int BLK2_W = PAGE_W + 3;
  localparam int BLK4_W = PAGE_W + 4;
  localparam int T_MAX  = imax(imax(imax(T_BYTE, T_PAGE), imax(T_AUTO, T_PERASE)),
                               imax(T_BLK2, T_BLK4));
  localparam int CW     = $clog2(T_MAX + 1);

  kind_e             kind_q;
  logic              armed_q;
  logic [AW-1:0]     addr_q;
  logic [7:0]        last_byte_q;
  logic              hit_prot, start;
  logic [CW-1:0]     len;
  logic [PAGE_W-1:0] buf_idx;
  logic [7:0]        buf_data;
  logic              buf_wr, is_page;
  logic              unused_addr_hi;

  assign unused_addr_hi = ^addr_i[23:AW];

  assign is_page  = (kind_q == K_PAGE) || (kind_q == K_AUTO);
  assign buf_wr   = data_valid_i && armed_q && !busy_o && is_page;
  assign hit_prot = &addr_q[AW-1 -: PROT_W];
  assign start    = cs_rise_i && armed_q && !busy_o && !(hit_prot && !lock_top_ni);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q      <= K_NONE;
      armed_q     <= 1'b0;
      addr_q      <= '0;
      last_byte_q <= '1;
    end else if (!busy_o) begin
      if (cs_rise_i) begin
        kind_q  <= K_NONE;
        armed_q <= 1'b0;
      end else if (op_valid_i) begin
        kind_q  <= decode_op(op_i);
        armed_q <= 1'b0;
      end else if (addr_valid_i && kind_q != K_NONE) begin
        addr_q  <= addr_i[AW-1:0];
        armed_q <= 1'b1;
      end else if (data_valid_i && armed_q && kind_q == K_BYTE) begin
        last_byte_q <= data_i;
      end
    end
  end

  always_comb begin
    case (kind_q)
      K_BYTE:   len = CW'(T_BYTE);
      K_PAGE:   len = CW'(T_PAGE);
      K_AUTO:   len = CW'(T_AUTO);
      K_PERASE: len = CW'(T_PERASE);
      K_BLK2:   len = CW'(T_BLK2);
      K_BLK4:   len = CW'(T_BLK4);
      default:  len = '0;
    endcase
  end

  pe_page_buf #(.PAGE_W(PAGE_W), .DW(8)) u_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (op_valid_i && !busy_o && !cs_rise_i),
    .set_ptr_i (addr_valid_i && !busy_o && !cs_rise_i && !op_valid_i && kind_q != K_NONE),
    .ptr_i     (addr_i[PAGE_W-1:0]),
    .wr_i      (buf_wr && !cs_rise_i && !op_valid_i && !addr_valid_i),
    .wdata_i   (data_i),
    .rd_idx_i  (buf_idx),
    .rd_data_o (buf_data)
  );

  pe_busy_timer #(.CW(CW)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .len_i   (len),
    .busy_o  (busy_o)
  );

  pe_walker #(
    .AW(AW), .PAGE_W(PAGE_W), .BLK2_W(BLK2_W), .BLK4_W(BLK4_W), .DW(8)
  ) u_walk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .kind_i      (kind_q),
    .addr_i      (addr_q),
    .byte_i      (last_byte_q),
    .buf_idx_o   (buf_idx),
    .buf_data_i  (buf_data),
    .arr_rdata_i (arr_rdata_i),
    .arr_we_o    (arr_we_o),
    .arr_addr_o  (arr_addr_o),
    .arr_wdata_o (arr_wdata_o)
  );

  // R12
  we_in_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_we_o |-> busy_o);
  // R9
  prot_refuse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_rise_i && armed_q && !busy_o && hit_prot && !lock_top_ni) |=> !busy_o);
  // R11
  busy_hold_kind_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && op_valid_i) |=> kind_q == $past(kind_q));
endmodule

// File: tb/pe_seq_bench.sv
`timescale 1ns/1ps
module pe_seq_bench;
  localparam int TB_BYTE = 8, TB_PAGE = 300, TB_AUTO = 560;
  localparam int TB_PERASE = 280, TB_BLK2 = 2100, TB_BLK4 = 4200;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        op_valid = 0, addr_valid = 0, data_valid = 0, cs_rise = 0, lock_n = 1;
  logic [7:0]  op = 0, data = 0, arr_rdata = 8'hFF, arr_wdata;
  logic [23:0] addr = 0;
  logic        busy, arr_we;
  logic [18:0] arr_addr;

  int checks = 0, fails = 0, exp_cnt = 0, start_len = 0;
  bit chk_on = 0, done = 0;
  logic [7:0] dut_mem [int];
  logic [7:0] ref_mem [int];

  always #10 clk = ~clk;

  pe_seq u_pe_seq (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(op_valid), .op_i(op),
    .addr_valid_i(addr_valid), .addr_i(addr), .data_valid_i(data_valid),
    .data_i(data), .cs_rise_i(cs_rise), .lock_top_ni(lock_n), .busy_o(busy),
    .arr_we_o(arr_we), .arr_addr_o(arr_addr), .arr_wdata_o(arr_wdata),
    .arr_rdata_i(arr_rdata)
  );

  function automatic logic [7:0] dut_rd(input int a);
    return dut_mem.exists(a) ? dut_mem[a] : 8'hFF;
  endfunction
  function automatic logic [7:0] ref_rd(input int a);
    return ref_mem.exists(a) ? ref_mem[a] : 8'hFF;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // array model of the device under test
  always @(posedge clk) if (rst_n && arr_we) dut_mem[int'(arr_addr)] = arr_wdata;
  always @(negedge clk) arr_rdata = dut_rd(int'(arr_addr));

  // busy reference: T cycles starting the cycle after the end strobe
  always @(posedge clk) begin
    if (cs_rise && start_len > 0) exp_cnt = start_len;
    else if (exp_cnt > 0) exp_cnt--;
  end

  // per-clock comparison (R10, R12)
  always @(negedge clk) if (chk_on) begin
    check(busy === (exp_cnt > 0), "R10 busy", int'(busy), int'(exp_cnt > 0));
    if (arr_we) check(exp_cnt > 0, "R12 write outside busy", 1, 0);
  end

  function automatic int op_len(input logic [7:0] o);
    case (o)
      8'h02: return TB_BYTE;   8'h11: return TB_PAGE;  8'h82: return TB_AUTO;
      8'h81: return TB_PERASE; 8'h50: return TB_BLK2;  8'h20: return TB_BLK4;
      default: return 0;
    endcase
  endfunction

  task automatic ref_apply(input logic [7:0] o, input int a, input logic [7:0] d[4], input int n);
    logic [7:0] pg [256];
    int base, off, sz;
    case (o)
      8'h02: if (n > 0) ref_mem[a] = ref_rd(a) & d[n-1];
      8'h11, 8'h82: begin
        for (int i = 0; i < 256; i++) pg[i] = 8'hFF;
        off = a & 255;
        for (int i = 0; i < n; i++) begin pg[off] = d[i]; off = (off + 1) & 255; end
        base = a & ~255;
        for (int i = 0; i < 256; i++)
          ref_mem[base+i] = (o == 8'h82) ? pg[i] : (ref_rd(base+i) & pg[i]);
      end
      8'h81, 8'h50, 8'h20: begin
        sz = (o == 8'h81) ? 256 : (o == 8'h50) ? 2048 : 4096;
        base = a & ~(sz - 1);
        for (int i = 0; i < sz; i++) ref_mem[base+i] = 8'hFF;
      end
      default: ;
    endcase
  endtask

  task automatic pulse_op(input logic [7:0] v);
    @(negedge clk); op_valid = 1; op = v;
    @(negedge clk); op_valid = 0;
  endtask

  task automatic cmd(input logic [7:0] o, input logic [23:0] ad,
                     input logic [7:0] d0, input logic [7:0] d1,
                     input logic [7:0] d2, input logic [7:0] d3,
                     input int n, input bit wait_done);
    logic [7:0] d[4];
    int a;
    bit ok;
    d[0] = d0; d[1] = d1; d[2] = d2; d[3] = d3;
    a = int'(ad & 24'h07FFFF);
    pulse_op(o);
    @(negedge clk); addr_valid = 1; addr = ad;
    @(negedge clk); addr_valid = 0;
    for (int i = 0; i < n; i++) begin
      data_valid = 1; data = d[i];
      @(negedge clk); data_valid = 0;
    end
    ok = (op_len(o) > 0) && (exp_cnt == 0) && !(((a >> 16) == 7) && !lock_n);
    if (ok) ref_apply(o, a, d, n);
    cs_rise = 1; start_len = ok ? op_len(o) : 0;
    @(negedge clk); cs_rise = 0; start_len = 0;
    if (wait_done) begin
      while (exp_cnt > 0) @(negedge clk);
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic chk_mem(input int a, input logic [7:0] exp, input string req);
    check(dut_rd(a) === exp, req, int'(dut_rd(a)), int'(exp));
    check(ref_rd(a) === exp, {req, " model"}, int'(ref_rd(a)), int'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(busy === 1'b0, "reset busy", int'(busy), 0);
    check(arr_we === 1'b0, "reset we", int'(arr_we), 0);
    chk_on = 1;

    // R2: last byte wins, high address bits dropped
    cmd(8'h02, 24'hF12345, 8'h11, 8'h22, 8'hA5, 8'h00, 3, 1);
    chk_mem(32'h12345, 8'hA5, "R2 last byte");
    cmd(8'h02, 24'h012345, 8'h3C, 8'h00, 8'h00, 8'h00, 1, 1);
    chk_mem(32'h12345, 8'h24, "R4 byte AND");

    // R3: fill from offset FEh wraps to 00h
    cmd(8'h11, 24'h0002FE, 8'h11, 8'h22, 8'h33, 8'h44, 4, 1);
    chk_mem(32'h2FE, 8'h11, "R3 offset FE");
    chk_mem(32'h2FF, 8'h22, "R3 offset FF");
    chk_mem(32'h200, 8'h33, "R3 wrap 00");
    chk_mem(32'h201, 8'h44, "R3 wrap 01");
    chk_mem(32'h250, 8'hFF, "R3 unloaded");

    // R4: AND with old data, unloaded bytes untouched
    cmd(8'h11, 24'h000201, 8'h0F, 8'h00, 8'h00, 8'h00, 1, 1);
    chk_mem(32'h201, 8'h04, "R4 page AND");
    chk_mem(32'h200, 8'h33, "R4 unloaded kept");

    // R5: auto-erase then program
    cmd(8'h82, 24'h000200, 8'hC3, 8'h00, 8'h00, 8'h00, 1, 1);
    chk_mem(32'h200, 8'hC3, "R5 programmed");
    chk_mem(32'h201, 8'hFF, "R5 erased");
    chk_mem(32'h2FE, 8'hFF, "R5 erased end");

    // R6: page erase
    cmd(8'h02, 24'h004301, 8'h00, 8'h00, 8'h00, 8'h00, 1, 1);
    cmd(8'h02, 24'h004400, 8'h77, 8'h00, 8'h00, 8'h00, 1, 1);
    cmd(8'h81, 24'h0043C7, 8'h00, 8'h00, 8'h00, 8'h00, 0, 1);
    chk_mem(32'h4301, 8'hFF, "R6 page erased");
    chk_mem(32'h4400, 8'h77, "R6 neighbour kept");

    // R7: 2 KB block erase
    cmd(8'h02, 24'h004800, 8'h12, 8'h00, 8'h00, 8'h00, 1, 1);
    cmd(8'h02, 24'h0047FF, 8'h34, 8'h00, 8'h00, 8'h00, 1, 1);
    cmd(8'h50, 24'h004ABC, 8'h00, 8'h00, 8'h00, 8'h00, 0, 1);
    chk_mem(32'h4800, 8'hFF, "R7 block start");
    chk_mem(32'h47FF, 8'h34, "R7 below kept");

    // R8: 4 KB block erase
    cmd(8'h02, 24'h005800, 8'h56, 8'h00, 8'h00, 8'h00, 1, 1);
    cmd(8'h02, 24'h006000, 8'h78, 8'h00, 8'h00, 8'h00, 1, 1);
    cmd(8'h20, 24'h005ABC, 8'h00, 8'h00, 8'h00, 8'h00, 0, 1);
    chk_mem(32'h5800, 8'hFF, "R8 block mid");
    chk_mem(32'h6000, 8'h78, "R8 above kept");

    // R9: protected region
    lock_n = 0;
    cmd(8'h02, 24'h07F000, 8'h00, 8'h00, 8'h00, 8'h00, 1, 1);
    chk_mem(32'h7F000, 8'hFF, "R9 refused");
    cmd(8'h02, 24'h06FFFF, 8'h81, 8'h00, 8'h00, 8'h00, 1, 1);
    chk_mem(32'h6FFFF, 8'h81, "R9 boundary open");
    lock_n = 1;
    cmd(8'h02, 24'h07F000, 8'h00, 8'h00, 8'h00, 8'h00, 1, 1);
    chk_mem(32'h7F000, 8'h00, "R9 unlocked");

    // R11: commands during busy discarded
    cmd(8'h81, 24'h06F000, 8'h00, 8'h00, 8'h00, 8'h00, 0, 0);
    cmd(8'h02, 24'h003000, 8'h00, 8'h00, 8'h00, 8'h00, 1, 1);
    chk_mem(32'h3000, 8'hFF, "R11 discarded");

    // R1: non-write opcode
    cmd(8'h0B, 24'h003000, 8'h00, 8'h00, 8'h00, 8'h00, 1, 1);
    chk_mem(32'h3000, 8'hFF, "R1 ignored opcode");
    check(busy === 1'b0, "R1 no busy", int'(busy), 0);

    finish_up();
  end
endmodule